// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets synchronous logic use an external asynchronous static RAM that has a 19-bit address, an 8-bit shared data bus and three active-low strobes: select, read-drive and write. On the user side, a request is offered with `req_valid` together with an address, write data and a direction flag. The request is taken on the first clock edge where `req_ready` is high. A read returns its byte on `rsp_rdata` with a one-cycle `rsp_ack` pulse.

The memory's timing is given in nanoseconds as parameters, together with the clock period. Each time is rounded up to whole clock cycles, with a minimum of one cycle. The sequencer then holds each strobe long enough to meet access time, cycle time, write pulse width, data and address setup to the end of write, and the time the memory needs to release the bus after a read.

The shared data bus is brought out as three pad-side signals: an output value, an output enable and an input value. The tristate buffer itself therefore sits in the pad ring.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_ack` is low.
- R2: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for RD_CYC consecutive cycles. RD_CYC is the larger of the access time and the cycle time in clock cycles, which is 4 at the defaults. The requested address is on `mem_addr` from the first of these cycles.
- R3: The byte on `mem_dq_i` is registered on the edge that ends the read strobe. `rsp_ack` is then high for exactly one cycle with that byte on `rsp_rdata`. `rsp_rdata` keeps the value until the next read completes.
- R4: A write holds `mem_we_n` and `mem_ce_n` low with `mem_oe_n` high for WS_CYC cycles. WS_CYC is the largest of the pulse width, data setup and address setup in cycles, and of the cycle time minus one; it is 3 at the defaults. After the strobe comes one cycle with `mem_we_n` high, `mem_ce_n` low, and address and data unchanged.
- R5: `mem_dq_oe` is high only during the write strobe and its trailing hold cycle. It is never high while the memory may be driving the bus.
- R6: After a read, `mem_ce_n` and `mem_oe_n` stay high for at least TA_CYC cycles (the output-disable time in cycles, 2 at the defaults) before the next access starts.
- R7: `req_ready` is high only while no access is in progress. A request presented while `req_ready` is low has no effect on the memory.
- R8: Read-after-write, write-after-read, back-to-back reads and overwrites return the most recently written byte for every address and data pattern.
- R9: The address stays stable for as long as `mem_ce_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request is taken on an edge where this is high |
| rsp_ack | output | 1 | One-cycle pulse when read data is valid |
| rsp_rdata | output | 8 | Last read byte |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output drive, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Value sampled from the data bus |

## Verification
The assertions assume the memory behaves like its truth table. It drives the bus only while selected with read-drive low and write high, and it releases the bus no later than TA_CYC cycles after read-drive rises. The bench's memory model does exactly this: its access delay is RD_CYC cycles and its release delay is TA_CYC cycles, so no model drive reaches past the turnaround window. User requests are changed only on falling edges. One extra request is raised on purpose while `req_ready` is low, and it is dropped before the block becomes ready again.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_WSTB  = 3'd3,
    ST_WHOLD = 3'd4
  } asram_state_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CW     = 3,
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WS_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          expired,
  output asram_state_e  state,
  output logic          accept,
  output logic          rd_done,
  output logic          load,
  output logic [CW-1:0] load_val
);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WS_LD = CW'(WS_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

  asram_state_e nxt;

  assign accept  = req_valid && (state == ST_IDLE);
  assign rd_done = (state == ST_READ) && expired;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        load = 1'b1;
        if (req_write) begin nxt = ST_WSTB; load_val = WS_LD; end
        else           begin nxt = ST_READ; load_val = RD_LD; end
      end
      ST_READ: if (expired) begin
        nxt = ST_TURN; load = 1'b1; load_val = TA_LD;
      end
      ST_TURN:  if (expired) nxt = ST_IDLE;
      ST_WSTB:  if (expired) nxt = ST_WHOLD;
      ST_WHOLD: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              ack_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_done) rdata_q <= mem_dq_i;
      ack_q <= rd_done;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned T_ACC_NS = 15,
  parameter int unsigned T_CYC_NS = 15,
  parameter int unsigned T_WP_NS  = 12,
  parameter int unsigned T_DW_NS  = 9,
  parameter int unsigned T_AW_NS  = 12,
  parameter int unsigned T_OHZ_NS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC  = max2(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_CYC_NS, CLK_NS));
  localparam int unsigned WS_CYC  = max2(max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)),
                                         max2(ns2cyc(T_AW_NS, CLK_NS), ns2cyc(T_CYC_NS, CLK_NS) - 1));
  localparam int unsigned TA_CYC  = ns2cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned CNT_MAX = max2(max2(RD_CYC, WS_CYC), TA_CYC);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  asram_state_e  state;
  logic          accept, rd_done, load, expired;
  logic [CW-1:0] load_val;

  // named events for the checker
  logic in_read, in_wstrobe, in_whold;
  assign in_read    = (state == ST_READ);
  assign in_wstrobe = (state == ST_WSTB);
  assign in_whold   = (state == ST_WHOLD);

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  asram_seq #(.CW(CW), .RD_CYC(RD_CYC), .WS_CYC(WS_CYC), .TA_CYC(TA_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .expired(expired), .state(state), .accept(accept), .rd_done(rd_done),
    .load(load), .load_val(load_val)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_done(rd_done),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
    .addr_q(mem_addr), .wdata_q(mem_dq_o), .rdata_q(rsp_rdata), .ack_q(rsp_ack)
  );

  assign mem_ce_n  = !(in_read || in_wstrobe || in_whold);
  assign mem_oe_n  = !in_read;
  assign mem_we_n  = !in_wstrobe;
  assign mem_dq_oe = in_wstrobe || in_whold;
  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WS_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);
  logic [7:0] we_lo_cnt;
  logic [7:0] oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= 8'hFF;
    end else begin
      we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      oe_hi_cnt <= !mem_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
    end
  end

  a_r2_read_keeps_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_oe_n) |-> mem_we_n);

  a_r3_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  a_r4_write_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= 8'(WS_CYC)));

  a_r4_write_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && !mem_ce_n && mem_dq_oe));

  a_r4_strobe_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_oe_n));

  a_r5_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  a_r6_turnaround_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(TA_CYC)));

  a_r7_ready_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  a_r9_addr_stable_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_CYC(WS_CYC), .TA_CYC(TA_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_ack(rsp_ack),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps

module asram_model #(
  parameter int unsigned ACC_CYC = 4,
  parameter int unsigned HZ_CYC  = 2
) (
  input  logic        clk,
  input  logic [18:0] addr,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [7:0]  bus,
  output logic        drive,
  output logic [7:0]  q
);
  logic [7:0] mem [64];
  logic [7:0] acc;
  logic [7:0] hz;
  logic [7:0] last_q;
  logic       rd_on;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    acc = 0; hz = 0; last_q = 0;
  end

  assign rd_on = !ce_n && !oe_n && we_n;

  always @(posedge clk) begin
    if (!ce_n && !we_n) mem[addr[5:0]] <= bus;
    acc <= rd_on ? acc + 8'd1 : 8'd0;
    if (rd_on) hz <= 8'(HZ_CYC);
    else if (hz != 0) hz <= hz - 8'd1;
    if (rd_on) last_q <= q;
  end

  always_comb begin
    drive = rd_on || (hz != 0);
    if (rd_on) q = (acc >= 8'(ACC_CYC - 1)) ? mem[addr[5:0]] : ~mem[addr[5:0]];
    else       q = last_q;
  end
endmodule

module asram_ctrl_bench;
  localparam int CLK = 4;
  localparam int RD  = (15 + CLK - 1) / CLK;
  localparam int WS  = (12 + CLK - 1) / CLK;
  localparam int TA  = (7 + CLK - 1) / CLK;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [18:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic        req_ready, rsp_ack, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i, model_q;
  logic [18:0] mem_addr;
  logic        model_drive;

  int tests = 0, fails = 0;
  int writes_issued = 0, wr_pulses = 0, contention = 0;
  logic [7:0]  shadow [64];
  logic [7:0]  exp_q [$];
  logic [18:0] cur_addr = 0;
  logic [7:0]  last_rd = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  asram_model #(.ACC_CYC(RD), .HZ_CYC(TA)) u_mem (
    .clk(clk), .addr(mem_addr), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .bus(mem_dq_i), .drive(model_drive), .q(model_q)
  );

  assign mem_dq_i = model_drive ? model_q : (mem_dq_oe ? mem_dq_o : 8'h00);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    cur_addr = a;
    if (wr) begin shadow[a[5:0]] = d; writes_issued++; end
    else exp_q.push_back(shadow[a[5:0]]);
    @(negedge clk);
    req_valid = 0;
  endtask

  // scoreboard monitor for read responses (R3, R8)
  always @(negedge clk) if (rst_n && rsp_ack) begin
    if (exp_q.size() == 0) check(0, "R3 unexpected ack", 1, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(rsp_rdata == e, "R8 read data", rsp_rdata, e);
      last_rd = e;
    end
  end

  // strobe shape monitors
  int we_cnt = 0, oe_cnt = 0, ce_hi = 0;
  bit after_rd = 0;
  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe && model_drive) contention++;
    if (!mem_we_n) begin
      we_cnt++;
      if (we_cnt == 1) check(mem_addr == cur_addr, "R4 write address", mem_addr, cur_addr);
    end else if (we_cnt > 0) begin
      check(we_cnt == WS, "R4 write strobe length", we_cnt, WS);
      check(!mem_ce_n && mem_dq_oe && mem_addr == cur_addr, "R4 hold cycle", {mem_ce_n, mem_dq_oe}, 2'b01);
      wr_pulses++;
      we_cnt = 0;
    end
    if (!mem_oe_n) begin
      oe_cnt++;
      if (oe_cnt == 1) check(mem_addr == cur_addr && !mem_ce_n, "R2 read address", mem_addr, cur_addr);
    end else if (oe_cnt > 0) begin
      check(oe_cnt == RD, "R2 read strobe length", oe_cnt, RD);
      oe_cnt = 0; after_rd = 1; ce_hi = 0;
    end
    if (mem_ce_n) ce_hi++;
    else if (after_rd) begin
      check(ce_hi >= TA, "R6 turnaround", ce_hi, TA);
      after_rd = 0;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_ack,
          "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_ack}, 6'b111010);
    rst_n = 1;
    @(negedge clk);
    check(mem_ce_n && req_ready && !rsp_ack, "R1 after reset", {mem_ce_n, req_ready, rsp_ack}, 3'b110);

    issue(1, 19'd1, 8'h5A);
    issue(0, 19'd1, 8'h00);          // read after write
    issue(1, 19'd2, 8'hFF);          // write after read
    issue(1, 19'd63, 8'h00);         // write after write
    issue(0, 19'd2, 8'h00);
    issue(0, 19'd63, 8'h00);         // back-to-back reads
    issue(0, 19'd7, 8'h00);          // never written
    issue(1, 19'h7FFC5, 8'hA5);      // high address bits
    issue(0, 19'h7FFC5, 8'h00);
    issue(1, 19'd1, 8'h3C);          // overwrite
    issue(0, 19'd1, 8'h00);

    // R7: request while busy has no effect
    issue(1, 19'd9, 8'h11);
    check(!req_ready, "R7 busy after accept", req_ready, 0);
    req_valid = 1; req_write = 1; req_addr = 19'd9; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 0;
    issue(0, 19'd9, 8'h00);

    for (int k = 0; k < 8; k++) issue(1, 19'(20 + k), 8'(8'h81 ^ (k * 37)));
    for (int k = 0; k < 8; k++) issue(0, 19'(20 + k), 8'h00);

    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads acknowledged", exp_q.size(), 0);
    check(rsp_rdata == last_rd, "R3 read data held", rsp_rdata, last_rd);
    check(wr_pulses == writes_issued, "R7 write pulse count", wr_pulses, writes_issued);
    check(contention == 0, "R5 bus contention", contention, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule